// File: doc/BRIEF.md
# Audio Transmit Sample FIFO Controller

This block is the feeding stage in front of a serial digital-audio frame encoder. A bus master or a DMA engine writes sample words into one write port. The block turns each word into a 24-bit payload and queues it in an eight-entry FIFO. The encoder fetches one payload at a time through a single-cycle take strobe. A DMA request output asks for more data whenever the FIFO has a free slot. A programmable hold-off, counted in bus clock cycles, spaces each request from the write before it, which caps the share of bus bandwidth the stream consumes.

One control word holds all the settings: the run bit, the drain-on-stop option, the input word length, the interrupt enable, the request hold-off, the clock gate and the soft reset. When the encoder asks for a sample while the FIFO is empty, the block sends a zero payload so the frame timing holds. It also sets a sticky underflow flag, which only a dedicated clear address can reset. When a drain-on-stop completes, the block raises an end-of-transfer flag.

The write port decodes these addresses. Address 0 is the control word. Address 1 is the underflow clear alias. Address 2 is the sample data. Address 3 has no effect.

Top module: `aud_tx_front`

## Requirements
- R1: After the synchronous reset, dma_req, enc_valid, stat_underflow, stat_xfer_end and irq are all 0. The control word is cleared, so the block is idle and not gated.
- R2: When control bit 2 (half-word mode) is 1, a data write stores the low 16 bits of wr_data as payload bits 23:8 and sets payload bits 7:0 to zero. Bits 31:16 of the written word are ignored.
- R3: When control bit 2 is 0, a data write stores wr_data[31:8] as the payload and discards wr_data[7:0].
- R4: Control bits 8:4 hold a hold-off D from 0 to 31. After each accepted data write, dma_req stays low for exactly D clock cycles and then rises again, provided the block is running and the FIFO has room.
- R5: The FIFO holds 8 payloads and delivers them in write order. A data write to a full FIFO is dropped. dma_req is 0 while the FIFO is full.
- R6: Control bit 0 (run) starts transmission. If control bit 1 (drain-on-stop) is 0, clearing run stops delivery at once. Later takes then produce no sample, the queued payloads are kept for the next run, and stat_xfer_end stays 0.
- R7: If drain-on-stop is 1, clearing run keeps serving takes until the FIFO is empty. The block then halts and sets stat_xfer_end, including when the FIFO was already empty at the stop. dma_req is 0 while draining, and setting run again clears stat_xfer_end.
- R8: A take while running with an empty FIFO produces enc_valid with an all-zero payload and sets stat_underflow.
- R9: stat_underflow is sticky. A control write does not clear it, and a write to address 1 with bit 0 at 0 does not clear it. Only a write to address 1 with bit 0 at 1 clears it.
- R10: irq is 1 one cycle after stat_underflow and control bit 3 (interrupt enable) are both 1, and 0 one cycle after either of them is 0.
- R11: A control write with bit 31 at 1 flushes the FIFO, clears both status flags and the other settings, and sets the clock gate. The block stays inert until a control write with bits 31 and 30 at 0.
- R12: While control bit 30 (clock gate) is 1, the block keeps its FIFO and state, data writes are dropped, takes produce no sample and dma_req is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 underflow clear, 2 sample data |
| wr_data | input | 32 | Write data |
| enc_take | input | 1 | Encoder request for the next sample |
| dma_req | output | 1 | Request for another sample write |
| enc_valid | output | 1 | One-cycle pulse marking a delivered sample |
| enc_data | output | 24 | Payload delivered to the encoder |
| stat_underflow | output | 1 | Sticky underflow flag |
| stat_xfer_end | output | 1 | Drain-on-stop completed |
| irq | output | 1 | Underflow interrupt |

## Verification
The hardest condition to reach is a drain that finishes at the FIFO's empty point. The flag has to come from the last pop, not from the stop command. The bench gets there by queueing a few samples, clearing run with drain-on-stop set, and taking exactly as many samples as were queued. It then checks that the flag rises one cycle later and that a further take yields nothing. A second pass clears run with the FIFO already empty. The hold-off is swept over all 32 values, and each time the bench counts the low cycles of the request after a write it places itself.

// File: rtl/aud_tx_pkg.sv
`timescale 1ns/1ps
package aud_tx_pkg;
  localparam int REG_AW = 2;

  localparam logic [REG_AW-1:0] A_CTRL = 2'd0;
  localparam logic [REG_AW-1:0] A_CLR  = 2'd1;
  localparam logic [REG_AW-1:0] A_DATA = 2'd2;

  // control word bit positions
  localparam int B_RUN   = 0;
  localparam int B_DRAIN = 1;
  localparam int B_HALF  = 2;
  localparam int B_IEN   = 3;
  localparam int B_DLY   = 4;
  localparam int B_GATE  = 30;
  localparam int B_SRST  = 31;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2
  } tx_st_e;
endpackage

// File: rtl/aud_tx_regs.sv
`timescale 1ns/1ps
module aud_tx_regs import aud_tx_pkg::*; #(
  parameter int DATA_W = 32,
  parameter int DLY_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              run_q,
  output logic              drain_q,
  output logic              half_q,
  output logic              ien_q,
  output logic [DLY_W-1:0]  dly_q,
  output logic              gate_q,
  output logic              srst_q,
  output logic              srst_hit,
  output logic              clr_uf,
  output logic              data_wr
);
  logic ctrl_wr;

  always_comb begin
    ctrl_wr  = wr_en && (wr_addr == A_CTRL);
    srst_hit = ctrl_wr && wr_data[B_SRST];
    clr_uf   = wr_en && (wr_addr == A_CLR) && wr_data[0];
    data_wr  = wr_en && (wr_addr == A_DATA);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= 1'b0;
      drain_q <= 1'b0;
      half_q  <= 1'b0;
      ien_q   <= 1'b0;
      dly_q   <= '0;
      gate_q  <= 1'b0;
      srst_q  <= 1'b0;
    end else if (srst_hit) begin
      run_q   <= 1'b0;
      drain_q <= 1'b0;
      half_q  <= 1'b0;
      ien_q   <= 1'b0;
      dly_q   <= '0;
      gate_q  <= 1'b1;
      srst_q  <= 1'b1;
    end else if (ctrl_wr) begin
      run_q   <= wr_data[B_RUN];
      drain_q <= wr_data[B_DRAIN];
      half_q  <= wr_data[B_HALF];
      ien_q   <= wr_data[B_IEN];
      dly_q   <= wr_data[B_DLY +: DLY_W];
      gate_q  <= wr_data[B_GATE];
      srst_q  <= 1'b0;
    end
  end
endmodule

// File: rtl/aud_tx_fifo.sv
`timescale 1ns/1ps
module aud_tx_fifo #(
  parameter int PAY_W = 24,
  parameter int DEPTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic             push,
  input  logic [PAY_W-1:0] push_data,
  input  logic             pop,
  input  logic             zap,
  output logic [PAY_W-1:0] rd_data,
  output logic [CNT_W-1:0] level,
  output logic             empty,
  output logic             full,
  output logic             pushed
);
  logic [PAY_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wp, rp;
  logic             do_pop;

  always_comb begin
    empty  = (level == '0);
    full   = (level == CNT_W'(DEPTH));
    pushed = push && !full && !hold;
    do_pop = pop && !empty && !hold;
  end

  // storage: no reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (pushed) mem[wp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst)         rd_data <= '0;
    else if (do_pop) rd_data <= mem[rp];
    else if (zap)    rd_data <= '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (pushed) wp <= (wp == PTR_W'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_pop) rp <= (rp == PTR_W'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({pushed, do_pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/aud_tx_pacer.sv
`timescale 1ns/1ps
module aud_tx_pacer #(
  parameter int DLY_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic [DLY_W-1:0] dly,
  input  logic             accepted,
  input  logic             allow,
  output logic             dma_req
);
  logic [DLY_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                cnt <= '0;
    else if (hold)          cnt <= cnt;
    else if (accepted)      cnt <= dly;
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  always_comb dma_req = allow && !hold && (cnt == '0);
endmodule

// File: rtl/aud_tx_seq.sv
`timescale 1ns/1ps
module aud_tx_seq import aud_tx_pkg::*; (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  input  logic run,
  input  logic drain,
  input  logic ien,
  input  logic take,
  input  logic empty,
  input  logic clr_uf,
  output logic pop,
  output logic zap,
  output logic running,
  output logic enc_valid,
  output logic uf,
  output logic xe,
  output logic irq
);
  tx_st_e st;
  logic   active;

  always_comb begin
    active  = !hold && ((st == ST_RUN) || (st == ST_DRAIN));
    pop     = take && active && !empty;
    zap     = take && !hold && (st == ST_RUN) && empty;
    running = (st == ST_RUN);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      enc_valid <= 1'b0;
      uf        <= 1'b0;
      xe        <= 1'b0;
      irq       <= 1'b0;
    end else begin
      enc_valid <= pop || zap;
      irq       <= uf && ien;
      if (zap)         uf <= 1'b1;
      else if (clr_uf) uf <= 1'b0;
      if (!hold) begin
        case (st)
          ST_IDLE: if (run) begin
            st <= ST_RUN;
            xe <= 1'b0;
          end
          ST_RUN: if (!run) begin
            if (drain && !empty) st <= ST_DRAIN;
            else begin
              st <= ST_IDLE;
              xe <= drain;
            end
          end
          ST_DRAIN: if (run) st <= ST_RUN;
            else if (empty) begin
              st <= ST_IDLE;
              xe <= 1'b1;
            end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/aud_tx_front.sv
`timescale 1ns/1ps
module aud_tx_front import aud_tx_pkg::*; #(
  parameter int DATA_W = 32,
  parameter int PAY_W  = 24,
  parameter int DEPTH  = 8,
  parameter int DLY_W  = 5,
  localparam int HALF_W = DATA_W / 2,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              enc_take,
  output logic              dma_req,
  output logic              enc_valid,
  output logic [PAY_W-1:0]  enc_data,
  output logic              stat_underflow,
  output logic              stat_xfer_end,
  output logic              irq
);
  logic run_q, drain_q, half_q, irq_en_q, gate_q, srst_q;
  logic srst_hit, clr_uf, data_wr;
  logic [DLY_W-1:0] dly_q;
  logic blk_rst;
  logic [PAY_W-1:0] pay;
  logic [CNT_W-1:0] fifo_cnt;
  logic fifo_empty, fifo_full, fifo_pushed;
  logic pop, zap, running;

  aud_tx_regs #(.DATA_W(DATA_W), .DLY_W(DLY_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .run_q(run_q), .drain_q(drain_q), .half_q(half_q), .ien_q(irq_en_q),
    .dly_q(dly_q), .gate_q(gate_q), .srst_q(srst_q),
    .srst_hit(srst_hit), .clr_uf(clr_uf), .data_wr(data_wr)
  );

  always_comb begin
    blk_rst = rst || srst_q || srst_hit;
    if (half_q) pay = {wr_data[HALF_W-1:0], {(PAY_W-HALF_W){1'b0}}};
    else        pay = wr_data[DATA_W-1 -: PAY_W];
  end

  aud_tx_fifo #(.PAY_W(PAY_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(blk_rst), .hold(gate_q), .push(data_wr), .push_data(pay),
    .pop(pop), .zap(zap), .rd_data(enc_data), .level(fifo_cnt),
    .empty(fifo_empty), .full(fifo_full), .pushed(fifo_pushed)
  );

  aud_tx_pacer #(.DLY_W(DLY_W)) u_pacer (
    .clk(clk), .rst(blk_rst), .hold(gate_q), .dly(dly_q),
    .accepted(fifo_pushed), .allow(running && !fifo_full), .dma_req(dma_req)
  );

  aud_tx_seq u_seq (
    .clk(clk), .rst(blk_rst), .hold(gate_q), .run(run_q), .drain(drain_q),
    .ien(irq_en_q), .take(enc_take), .empty(fifo_empty), .clr_uf(clr_uf),
    .pop(pop), .zap(zap), .running(running), .enc_valid(enc_valid),
    .uf(stat_underflow), .xe(stat_xfer_end), .irq(irq)
  );
endmodule

// File: rtl/aud_tx_front_chk.sv
`timescale 1ns/1ps
module aud_tx_front_chk import aud_tx_pkg::*; #(
  parameter int DEPTH = 8,
  parameter int CNT_W = 4,
  parameter int PAY_W = 24,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [REG_AW-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              dma_req,
  input logic              enc_valid,
  input logic [PAY_W-1:0]  enc_data,
  input logic              uf,
  input logic              xe,
  input logic              irq,
  input logic              irq_en,
  input logic              gate,
  input logic [CNT_W-1:0]  level
);
  assert_level_bound_R5: assert property (@(posedge clk) disable iff (rst)
    level <= CNT_W'(DEPTH));

  assert_no_req_when_full_R5: assert property (@(posedge clk) disable iff (rst)
    dma_req |-> (level < CNT_W'(DEPTH)));

  assert_zero_on_underflow_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(uf) |-> (enc_valid && (enc_data == '0)));

  assert_uf_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (uf && !(wr_en && (wr_addr == A_CTRL) && wr_data[B_SRST])
        && !(wr_en && (wr_addr == A_CLR) && wr_data[0])) |=> uf);

  assert_irq_set_R10: assert property (@(posedge clk) disable iff (rst)
    (uf && irq_en) |=> irq);

  assert_irq_clear_R10: assert property (@(posedge clk) disable iff (rst)
    !(uf && irq_en) |=> !irq);

  assert_gate_no_req_R12: assert property (@(posedge clk) disable iff (rst)
    gate |-> !dma_req);

  assert_gate_no_sample_R12: assert property (@(posedge clk) disable iff (rst)
    gate |=> !enc_valid);

  assert_end_when_empty_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(xe) |-> ($past(level) == '0));
endmodule

bind aud_tx_front aud_tx_front_chk #(
  .DEPTH(DEPTH), .CNT_W(CNT_W), .PAY_W(PAY_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .dma_req(dma_req), .enc_valid(enc_valid), .enc_data(enc_data),
  .uf(stat_underflow), .xe(stat_xfer_end), .irq(irq),
  .irq_en(irq_en_q), .gate(gate_q), .level(fifo_cnt)
);

// File: tb/sim_aud_tx_front.sv
`timescale 1ns/1ps
module sim_aud_tx_front;
  import aud_tx_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        enc_take = 1'b0;
  logic        dma_req, enc_valid, stat_underflow, stat_xfer_end, irq;
  logic [23:0] enc_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  aud_tx_front u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .enc_take(enc_take), .dma_req(dma_req), .enc_valid(enc_valid),
    .enc_data(enc_data), .stat_underflow(stat_underflow),
    .stat_xfer_end(stat_xfer_end), .irq(irq)
  );

  function automatic logic [31:0] cw(input bit run, input bit drain, input bit half,
                                     input bit ien, input int dly, input bit gate,
                                     input bit srst);
    logic [4:0] d = dly[4:0];
    return {srst, gate, 21'b0, d, ien, half, drain, run};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic take();
    @(negedge clk);
    enc_take = 1'b1;
    @(negedge clk);
    enc_take = 1'b0;
  endtask

  initial begin
    logic [31:0] w [9];
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 dma_req", dma_req, 0);
    chk("R1 enc_valid", enc_valid, 0);
    chk("R1 underflow", stat_underflow, 0);
    chk("R1 xfer_end", stat_xfer_end, 0);
    chk("R1 irq", irq, 0);

    // R3 / R5: fill while idle in 32-bit mode, overflow write dropped
    for (int i = 0; i < 9; i++) begin
      w[i] = 32'hA5000000 + i * 32'h01234567;
      wr(A_DATA, w[i]);
    end
    wr(A_CTRL, cw(1, 0, 0, 0, 0, 0, 0));
    @(negedge clk);
    chk("R5 no request when full", dma_req, 0);
    for (int i = 0; i < 8; i++) begin
      take();
      chk("R5 sample valid", enc_valid, 1);
      chk("R3 payload top 24 bits", enc_data, {8'h0, w[i][31:8]});
    end
    // R8 underflow
    take();
    chk("R8 underflow valid", enc_valid, 1);
    chk("R8 underflow zero payload", enc_data, 0);
    chk("R8 underflow flag", stat_underflow, 1);
    chk("R10 irq off while disabled", irq, 0);
    wr(A_CTRL, cw(1, 0, 0, 1, 0, 0, 0));
    @(negedge clk);
    chk("R10 irq on", irq, 1);
    chk("R9 ctrl write keeps flag", stat_underflow, 1);
    wr(A_CLR, 32'hFFFF_FFFE);
    chk("R9 clear alias bit0=0 keeps flag", stat_underflow, 1);
    wr(A_CLR, 32'h1);
    chk("R9 clear alias clears flag", stat_underflow, 0);
    @(negedge clk);
    chk("R10 irq off after clear", irq, 0);

    // R2 half-word sweep
    wr(A_CTRL, cw(1, 0, 1, 0, 0, 0, 0));
    for (int i = 0; i < 64; i++) begin
      logic [15:0] s;
      s = 16'(i * 16'h0413 + 16'h8001);
      wr(A_DATA, {16'hDEAD ^ 16'(i), s});
      take();
      chk("R2 valid", enc_valid, 1);
      chk("R2 half-word payload", enc_data, {8'h0, s, 8'h00});
    end

    // R4 hold-off sweep over all 32 values
    for (int d = 0; d < 32; d++) begin
      int n;
      int t;
      wr(A_CTRL, cw(1, 0, 0, 0, d, 0, 0));
      t = 0;
      while (!dma_req && t < 100) begin
        @(negedge clk);
        t++;
      end
      chk("R4 request present before write", dma_req, 1);
      wr_en = 1'b1; wr_addr = A_DATA; wr_data = 32'h12345600 + d;
      @(negedge clk);
      wr_en = 1'b0;
      n = 0;
      while (!dma_req && n < 40) begin
        n++;
        @(negedge clk);
      end
      chk("R4 request hold-off cycles", n, d);
      take();
      chk("R4 pushed sample delivered", enc_data, 24'h123456);
    end

    // R6 stop without drain keeps contents
    wr(A_CTRL, cw(1, 0, 0, 0, 0, 0, 0));
    for (int i = 0; i < 3; i++) wr(A_DATA, 32'h00100000 * (i + 1));
    wr(A_CTRL, cw(0, 0, 0, 0, 0, 0, 0));
    take();
    chk("R6 no sample after stop", enc_valid, 0);
    chk("R6 no underflow after stop", stat_underflow, 0);
    chk("R6 no xfer_end", stat_xfer_end, 0);
    wr(A_CTRL, cw(1, 0, 0, 0, 0, 0, 0));
    for (int i = 0; i < 3; i++) begin
      take();
      chk("R6 kept sample", enc_data, 24'(32'h00100000 * (i + 1) >> 8));
    end

    // R7 drain on stop
    wr(A_CTRL, cw(1, 1, 0, 0, 0, 0, 0));
    for (int i = 0; i < 3; i++) wr(A_DATA, 32'hC0000000 + (i << 12));
    wr(A_CTRL, cw(0, 1, 0, 0, 0, 0, 0));
    @(negedge clk);
    chk("R7 no request while draining", dma_req, 0);
    for (int i = 0; i < 3; i++) begin
      take();
      chk("R7 drained valid", enc_valid, 1);
      chk("R7 drained sample", enc_data, 24'((32'hC0000000 + (i << 12)) >> 8));
    end
    @(negedge clk);
    chk("R7 xfer_end after drain", stat_xfer_end, 1);
    take();
    chk("R7 no sample after halt", enc_valid, 0);
    chk("R7 no underflow after halt", stat_underflow, 0);
    wr(A_CTRL, cw(1, 1, 0, 0, 0, 0, 0));
    @(negedge clk);
    chk("R7 restart clears xfer_end", stat_xfer_end, 0);
    wr(A_CTRL, cw(0, 1, 0, 0, 0, 0, 0));
    @(negedge clk);
    chk("R7 xfer_end on empty stop", stat_xfer_end, 1);

    // R12 clock gate holds state
    wr(A_CTRL, cw(1, 0, 0, 0, 0, 0, 0));
    wr(A_DATA, 32'h11111100);
    wr(A_DATA, 32'h22222200);
    wr(A_CTRL, cw(1, 0, 0, 0, 0, 1, 0));
    take();
    chk("R12 no sample while gated", enc_valid, 0);
    chk("R12 no request while gated", dma_req, 0);
    wr(A_DATA, 32'h33333300);
    repeat (3) @(negedge clk);
    wr(A_CTRL, cw(1, 0, 0, 0, 0, 0, 0));
    take();
    chk("R12 first held sample", enc_data, 24'h111111);
    take();
    chk("R12 second held sample", enc_data, 24'h222222);
    take();
    chk("R12 gated write dropped", enc_data, 0);
    chk("R12 underflow after held samples", stat_underflow, 1);
    wr(A_CLR, 32'h1);

    // R11 soft reset
    take();
    chk("R11 underflow set before reset", stat_underflow, 1);
    wr(A_DATA, 32'h44444400);
    wr(A_DATA, 32'h55555500);
    wr(A_CTRL, 32'h8000_0000);
    chk("R11 flag cleared", stat_underflow, 0);
    chk("R11 no request", dma_req, 0);
    take();
    chk("R11 inert after reset", enc_valid, 0);
    wr(A_CTRL, cw(1, 0, 0, 0, 0, 0, 0));
    take();
    chk("R11 flushed valid", enc_valid, 1);
    chk("R11 flushed payload zero", enc_data, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    done = 1'b1;
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule